// File: doc/BRIEF.md
# Third-Order Fixed-Point Lowpass Filter

This block filters a stream of 16-bit two's-complement samples through a third-order lowpass IIR response. The response is built as a chain of two sections: a second-order section first, then a first-order section. Both sections use the transposed direct form II arrangement. Each section keeps its internal state at twice the sample width, which limits quantisation noise and limit cycles, and rounds its result back to 16 bits before handing it on.

A sample enters on a one-cycle strobe and the filtered sample leaves with its own strobe. Strobes may come every cycle or with gaps of any length. The coefficients are fixed when the block is built and are held at a wider width than the samples. A parameter sets the number of guard bits: it moves the state's binary point and so trades headroom against resolution.

Top module: `iir_lp3_cascade`

## Requirements
- R1: Each cycle with `in_valid` high gives exactly one `out_valid` pulse two clock edges later. `out_valid` is never high without a matching strobe.
- R2: The second-order section first forms y = s1 + b0·x. It then updates s1 ← s2 + b1·x − a1·y and s2 ← b2·x − a2·y, where y is the section's rounded 16-bit output.
- R3: Each state register is 2·DW = 32 bits wide with DW−1+GUARD fraction bits. Each product is aligned to that binary point by an arithmetic right shift (floor) of DW−1+CFRAC−(DW−1+GUARD) bits before it is summed.
- R4: The first-order section takes its input from the second-order section's rounded 16-bit output.
- R5: Coefficients are CW = 20-bit signed values with CFRAC = 17 fraction bits, so magnitudes up to 4 can be represented. Every product is a full-width signed product of DW+CW bits.
- R6: The first-order section forms y = s + c0·x and then updates s ← c1·x − d1·y, with one 32-bit state.
- R7: A section output is rounded to nearest, with halves rounded upward: add 2^(GUARD−1), then shift right arithmetically by GUARD. The result is then clamped to [−32768, 32767].
- R8: Every sum that lands in a state, and the pre-rounding output sum, is clamped to the 32-bit signed range instead of wrapping.
- R9: A synchronous active-high reset clears every state, the output sample and `out_valid` to zero. Samples presented during reset are ignored.
- R10: With all state at zero, a zero input yields an exactly zero output and leaves the state at zero.
- R11: A constant input of −32768 settles to within 4 LSB of the input times the DC gain of the quantised coefficients (about −32758 for the default set).
- R12: In cycles without a strobe, the states and `out_sample` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW (16) | Signed input sample, 15 fraction bits |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DW (16) | Signed filtered sample, held between strobes |

## Verification
Within a single sample, a section can clamp its state accumulator and also round and clip its output. Both happen when the output is pinned at a rail while the recursion is still pushing. This is provoked with a second instance built with 16 guard bits, whose state range is only ±1 full scale, driven by full-scale square waves and steps with random strobe gaps. Every output is compared bit for bit against an integer model in the bench that applies the floor alignment, rounding and clamping rules in the stated order.

// File: rtl/iir_lp3_pkg.sv
package iir_lp3_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Width of the summing path: the wider of state and product, plus carry room
  function automatic int sum_width(input int state_w, input int prod_w);
    return ((state_w > prod_w) ? state_w : prod_w) + 3;
  endfunction

  // Number of bits a full product is shifted right to reach the state point
  function automatic int align_shift(input int dw, input int cfrac, input int guard);
    return cfrac - guard + 0 * dw;
  endfunction
endpackage

// File: rtl/iir_term.sv
module iir_term #(
  parameter int DW = 16,
  parameter int CW = 20,
  parameter int SH = 9,
  parameter int AW = 39
) (
  input  logic signed [DW-1:0] smp,
  input  logic signed [CW-1:0] coef,
  output logic signed [AW-1:0] term
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] aligned;

  always_comb begin
    prod    = PW'(smp) * PW'(coef);
    aligned = prod >>> SH;
    term    = AW'(aligned);
  end
endmodule

// File: rtl/iir_df2t_sec.sv
module iir_df2t_sec
  import iir_lp3_pkg::*;
#(
  parameter int ORDER = 2,
  parameter int DW    = 16,
  parameter int CW    = 20,
  parameter int CFRAC = 17,
  parameter int GUARD = 8,
  parameter logic [(ORDER+1)*CW-1:0] B_VEC = '0,
  parameter logic [ORDER*CW-1:0]     A_VEC = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_smp,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_smp
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SW  = 2 * DW;
  localparam int PW  = DW + CW;
  localparam int AW  = sum_width(SW, PW);
  localparam int SH  = align_shift(DW, CFRAC, GUARD);
  localparam int RSH = GUARD;
  localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (RSH - 1));

  function automatic logic signed [SW-1:0] clamp_state(input logic signed [AW-1:0] v);
    if (v[AW-1:SW-1] == {(AW-SW+1){v[AW-1]}}) return v[SW-1:0];
    return v[AW-1] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
  endfunction

  function automatic logic signed [DW-1:0] clamp_smp(input logic signed [AW-1:0] v);
    if (v[AW-1:DW-1] == {(AW-DW+1){v[AW-1]}}) return v[DW-1:0];
    return v[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  logic signed [SW-1:0] st     [1:ORDER];
  logic signed [SW-1:0] st_nxt [1:ORDER];
  logic signed [CW-1:0] bc     [0:ORDER];
  logic signed [CW-1:0] ac     [1:ORDER];
  logic signed [AW-1:0] bx     [0:ORDER];
  logic signed [AW-1:0] ay     [1:ORDER];

  logic signed [AW-1:0] y_sum;
  logic signed [SW-1:0] y_full;
  logic signed [AW-1:0] y_shift;
  logic signed [DW-1:0] y_new;

  // Feed-forward products of the incoming sample
  for (genvar k = 0; k <= ORDER; k++) begin : g_ff
    assign bc[k] = B_VEC[k*CW +: CW];
    iir_term #(.DW(DW), .CW(CW), .SH(SH), .AW(AW)) u_bx (
      .smp (in_smp),
      .coef(bc[k]),
      .term(bx[k])
    );
  end

  // Output: oldest state plus b0*x, clamp, round, clip
  always_comb begin
    y_sum   = AW'(st[1]) + bx[0];
    y_full  = clamp_state(y_sum);
    y_shift = (AW'(y_full) + HALF) >>> RSH;
    y_new   = clamp_smp(y_shift);
  end

  // State chain: each state takes the next one plus its feed-forward and feedback terms
  for (genvar k = 1; k <= ORDER; k++) begin : g_state
    logic signed [AW-1:0] carry_in;
    if (k < ORDER) begin : g_mid
      assign carry_in = AW'(st[k+1]);
    end else begin : g_last
      assign carry_in = '0;
    end
    assign ac[k] = A_VEC[(k-1)*CW +: CW];
    iir_term #(.DW(DW), .CW(CW), .SH(SH), .AW(AW)) u_ay (
      .smp (y_new),
      .coef(ac[k]),
      .term(ay[k])
    );
    assign st_nxt[k] = clamp_state(carry_in + bx[k] - ay[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= ORDER; k++) st[k] <= '0;
      out_smp   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int k = 1; k <= ORDER; k++) st[k] <= st_nxt[k];
        out_smp <= y_new;
      end
    end
  end

  AST_ONE_OUT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(st[1]) && $stable(st[ORDER]))); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_smp)); // R12
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (st[1] == '0 && st[ORDER] == '0 && out_smp == '0 && !out_valid)); // R9
  AST_ZERO_REST: assert property (@(posedge clk) disable iff (rst) (in_valid && in_smp == '0 && st[1] == '0 && st[ORDER] == '0) |=> (out_smp == '0 && st[1] == '0 && st[ORDER] == '0)); // R10
endmodule

// File: rtl/iir_lp3_cascade.sv
module iir_lp3_cascade #(
  parameter int DW    = 16,
  parameter int CW    = 20,
  parameter int CFRAC = 17,
  parameter int GUARD = 8,
  parameter int SOS_B0 = 7699,
  parameter int SOS_B1 = 1571,
  parameter int SOS_B2 = 7699,
  parameter int SOS_A1 = -223596,
  parameter int SOS_A2 = 109498,
  parameter int FOS_C0 = 11469,
  parameter int FOS_C1 = 11469,
  parameter int FOS_D1 = -108134
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3*CW-1:0] SOS_BV = {CW'(SOS_B2), CW'(SOS_B1), CW'(SOS_B0)};
  localparam logic [2*CW-1:0] SOS_AV = {CW'(SOS_A2), CW'(SOS_A1)};
  localparam logic [2*CW-1:0] FOS_BV = {CW'(FOS_C1), CW'(FOS_C0)};
  localparam logic [CW-1:0]   FOS_AV = CW'(FOS_D1);

  logic                 mid_valid;
  logic signed [DW-1:0] mid_sample;

  iir_df2t_sec #(
    .ORDER(2), .DW(DW), .CW(CW), .CFRAC(CFRAC), .GUARD(GUARD),
    .B_VEC(SOS_BV), .A_VEC(SOS_AV)
  ) u_sos (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_smp   (in_sample),
    .out_valid(mid_valid),
    .out_smp  (mid_sample)
  );

  iir_df2t_sec #(
    .ORDER(1), .DW(DW), .CW(CW), .CFRAC(CFRAC), .GUARD(GUARD),
    .B_VEC(FOS_BV), .A_VEC(FOS_AV)
  ) u_fos (
    .clk      (clk),
    .rst      (rst),
    .in_valid (mid_valid),
    .in_smp   (mid_sample),
    .out_valid(out_valid),
    .out_smp  (out_sample)
  );

  AST_CHAIN_VALID: assert property (@(posedge clk) disable iff (rst) mid_valid |=> out_valid); // R4
  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst) !mid_valid |=> $stable(out_sample)); // R12
endmodule

// File: tb/iir_lp3_cascade_test.sv
module iir_lp3_cascade_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CFRAC = 17;
  localparam longint QB0 = 7699, QB1 = 1571, QB2 = 7699, QA1 = -223596, QA2 = 109498;
  localparam longint QC0 = 11469, QC1 = 11469, QD1 = -108134;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic ov_w, ov_n;
  logic signed [15:0] os_w, os_n;

  always #2 clk = ~clk;

  iir_lp3_cascade #(.GUARD(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_w), .out_sample(os_w)
  );

  iir_lp3_cascade #(.GUARD(16)) uut_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_n), .out_sample(os_n)
  );

  int checks = 0;
  int fails = 0;
  int clamps = 0;
  bit done = 1'b0;
  string tag = "R1";

  int     gd [2] = '{8, 16};
  longint bs1 [2], bs2 [2], fs [2], last_d [2], pd0 [2], pd1 [2];
  bit     pv0 [2], pv1 [2];

  function automatic longint satw(input longint v, input int w);
    longint mx = (64'sd1 <<< (w - 1)) - 1;
    longint mn = -mx - 1;
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic longint trm(input longint s, input longint c, input int sh);
    return (s * c) >>> sh;
  endfunction

  function automatic longint rnd16(input longint v, input int rsh);
    return satw((v + (64'sd1 <<< (rsh - 1))) >>> rsh, 16);
  endfunction

  function automatic longint cl32(input longint v);
    if (satw(v, 32) != v) clamps++;
    return satw(v, 32);
  endfunction

  task automatic model_step(input int m, input longint x, output longint y);
    int sh = CFRAC - gd[m];
    int rsh = gd[m];
    longint y1, n1, n2;
    y1 = rnd16(cl32(bs1[m] + trm(x, QB0, sh)), rsh);
    n1 = cl32(bs2[m] + trm(x, QB1, sh) - trm(y1, QA1, sh));
    n2 = cl32(trm(x, QB2, sh) - trm(y1, QA2, sh));
    bs1[m] = n1;
    bs2[m] = n2;
    y = rnd16(cl32(fs[m] + trm(y1, QC0, sh)), rsh);
    fs[m] = cl32(trm(y1, QC1, sh) - trm(y, QD1, sh));
  endtask

  task automatic check(input bit ok, input string tg, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
    end
  endtask

  task automatic chk_out();
    bit ov [2];
    longint os [2];
    ov[0] = ov_w; ov[1] = ov_n;
    os[0] = longint'(os_w); os[1] = longint'(os_n);
    for (int m = 0; m < 2; m++) begin
      check(ov[m] == pv1[m], "R1", "out_valid", longint'(ov[m]), longint'(pv1[m]));
      if (pv1[m]) begin
        check(os[m] == pd1[m], tag, "out_sample", os[m], pd1[m]);
        last_d[m] = pd1[m];
      end else begin
        check(os[m] == last_d[m], "R12", "held out_sample", os[m], last_d[m]);
      end
      pv1[m] = pv0[m];
      pd1[m] = pd0[m];
    end
  endtask

  task automatic cycle(input bit v, input longint x);
    longint y;
    @(negedge clk);
    chk_out();
    in_valid = v;
    in_sample = 16'(x);
    for (int m = 0; m < 2; m++) begin
      pv0[m] = v;
      pd0[m] = 0;
      if (v) begin
        model_step(m, x, y);
        pd0[m] = y;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_sample = 16'sh3039;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(ov_w == 1'b0 && os_w == 0, "R9", "wide cleared", longint'(os_w), 0);
    check(ov_n == 1'b0 && os_n == 0, "R9", "narrow cleared", longint'(os_n), 0);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      bs1[m] = 0; bs2[m] = 0; fs[m] = 0; last_d[m] = 0;
      pv0[m] = 0; pv1[m] = 0; pd0[m] = 0; pd1[m] = 0;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    longint dc_exp;
    do_reset();

    tag = "R10";
    for (int i = 0; i < 16; i++) cycle(1'b1, 0);

    tag = "R2/R3/R5/R6";
    cycle(1'b1, 32767);
    for (int i = 0; i < 63; i++) cycle(1'b1, 0);

    tag = "R2/R3/R4/R6";
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(1'b1, longint'($signed(lfsr)));
      if (lfsr[2:0] == 3'd0) cycle(1'b0, 0);
    end

    tag = "R11";
    for (int i = 0; i < 400; i++) cycle(1'b1, -32768);
    cycle(1'b0, 0);
    cycle(1'b0, 0);
    dc_exp = (-32768 * 16969) / 16974;
    check((longint'(os_w) - dc_exp <= 4) && (dc_exp - longint'(os_w) <= 4), "R11", "settled DC", longint'(os_w), dc_exp);

    tag = "R7/R8/R12";
    for (int i = 0; i < 200; i++) begin
      cycle(1'b1, (i % 2 == 1) ? 32767 : -32768);
      if (i % 3 == 2) cycle(1'b0, 0);
    end

    tag = "R4/R7/R8";
    for (int a = -32768; a <= 32767; a += 4369) begin
      for (int j = 0; j < 48; j++) begin
        cycle(1'b1, (j % 12 < 6) ? longint'(a) : longint'(-a - 1));
        if (j % 5 == 4) cycle(1'b0, 0);
      end
    end

    do_reset();
    tag = "R9/R10";
    for (int i = 0; i < 12; i++) cycle(1'b1, 0);
    for (int i = 0; i < 3; i++) cycle(1'b0, 0);

    $display("model clamp events: %0d", clamps);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule